// File: doc/BRIEF.md
# Receive FIFO Threshold and RTS Flow Controller

This block watches the fill level of a serial receiver's FIFO and compares it against two programmable thresholds. The first is a receive trigger level. When the FIFO reaches it, a flag is raised for use as an interrupt source. The second is a flow-delay level. When the FIFO reaches it, a status flag is raised and, while hardware flow control is on, the active-low request-to-send pin is deasserted so the far end stops sending.

Request-to-send is asserted again only after the FIFO has drained to at least four entries below the flow-delay level. When hardware flow control is off, the pin follows a software request bit. The FIFO storage, the transmit side and the other modem lines belong to neighbouring blocks.

All outputs are registered. A change of input is seen at the outputs after the next rising clock edge. A threshold write is stored at one edge and is used in the comparisons of the following cycle.

Top module: `rx_flow_ctrl`

## Requirements
- R1: `rxTrigFlag` is 1 after an edge at which the trigger threshold was nonzero and `fifoLevel` was greater than or equal to it, and 0 after any other edge.
- R2: A trigger threshold of 0 keeps `rxTrigFlag` at 0 for every FIFO level.
- R3: `flowDelayFlag` is 1 after an edge at which the flow-delay threshold was 4 or more and `fifoLevel` was greater than or equal to it. This flag is a status output only and never drives `rxTrigFlag`.
- R4: A flow-delay threshold below 4 keeps `flowDelayFlag` at 0 and, in flow control mode, keeps `rtsN` low for every FIFO level.
- R5: In flow control mode (`flowCtlMode`=1), `rtsN` goes high at the same edge at which `flowDelayFlag` goes high.
- R6: In flow control mode, after being deasserted, `rtsN` stays high until an edge at which the flow trigger is inactive and `fifoLevel` is no more than the threshold minus 4. At that edge `rtsN` returns low.
- R7: With `flowCtlMode`=0, `rtsN` after each edge equals the inverse of `swRts` before that edge.
- R8: A write (`trigWrEn` or `flowWrEn` high) updates its threshold at the clock edge. Comparisons in the write cycle still use the old value, and comparisons from the next cycle use the new value.
- R9: After reset, both thresholds are 0, both flags are 0 and `rtsN` is 1.
- R10: A FIFO level that jumps past a threshold, without ever equalling it, still activates the corresponding trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoLevel | input | 7 | Current receive FIFO occupancy |
| trigWrEn | input | 1 | Write strobe for the trigger threshold |
| trigWrData | input | 6 | New trigger threshold |
| flowWrEn | input | 1 | Write strobe for the flow-delay threshold |
| flowWrData | input | 6 | New flow-delay threshold |
| flowCtlMode | input | 1 | 1 = hardware flow control drives RTS |
| swRts | input | 1 | Software request-to-send bit (1 = assert) |
| rxTrigFlag | output | 1 | Receive trigger reached (interrupt source) |
| flowDelayFlag | output | 1 | Flow-delay trigger reached (status only) |
| rtsN | output | 1 | Request-to-send pin, active low |

## Verification
Two functions can land in the same cycle: the receive trigger firing and the flow-delay trigger deasserting RTS. The test provokes this by programming both thresholds to the same value and then stepping the FIFO level onto it. It then checks that both flags and the RTS rise appear after the same edge.

A second case combines a threshold write with a level change in the same cycle. It is judged by requiring the old threshold to govern that cycle and the new one to govern the next.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;
  localparam int THR_W = 6;
  localparam int LVL_W = 7;
  localparam int HYST  = 4;

  typedef struct packed {
    logic trigHit;
    logic flowHit;
    logic flowRelease;
    logic flowEnable;
  } cmpStrobe_t;
endpackage

// File: rtl/rx_flow_datapath.sv
module rx_flow_datapath
  import rx_flow_pkg::*;
#(
  parameter int ThrW  = THR_W,
  parameter int LvlW  = LVL_W,
  parameter int Hyst  = HYST
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LvlW-1:0] fifoLevel,
  input  logic            trigWrEn,
  input  logic [ThrW-1:0] trigWrData,
  input  logic            flowWrEn,
  input  logic [ThrW-1:0] flowWrData,
  output cmpStrobe_t      strobes
);
  localparam int CmpW = LvlW + 1;

  logic [ThrW-1:0] trigLevelQ;
  logic [ThrW-1:0] flowLevelQ;
  logic [CmpW-1:0] levelExt;
  logic [CmpW-1:0] trigExt;
  logic [CmpW-1:0] flowExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigLevelQ <= '0;
      flowLevelQ <= '0;
    end else begin
      if (trigWrEn) trigLevelQ <= trigWrData;
      if (flowWrEn) flowLevelQ <= flowWrData;
    end
  end

  always_comb begin
    levelExt = CmpW'(fifoLevel);
    trigExt  = CmpW'(trigLevelQ);
    flowExt  = CmpW'(flowLevelQ);
    strobes.trigHit     = (trigLevelQ != '0) && (levelExt >= trigExt);
    strobes.flowEnable  = (flowExt >= CmpW'(Hyst));
    strobes.flowHit     = strobes.flowEnable && (levelExt >= flowExt);
    strobes.flowRelease = strobes.flowEnable && !strobes.flowHit &&
                          ((levelExt + CmpW'(Hyst)) <= flowExt);
  end

  assert_trig_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trigLevelQ == '0) |-> !strobes.trigHit);
  assert_flow_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flowLevelQ < ThrW'(Hyst)) |-> (!strobes.flowHit && !strobes.flowRelease));
endmodule

// File: rtl/rx_flow_control.sv
module rx_flow_control
  import rx_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t strobes,
  input  logic       flowCtlMode,
  input  logic       swRts,
  output logic       rxTrigFlag,
  output logic       flowDelayFlag,
  output logic       rtsN
);
  logic holdQ;
  logic holdD;

  always_comb begin
    holdD = holdQ;
    if (!flowCtlMode || !strobes.flowEnable) holdD = 1'b0;
    else if (strobes.flowHit)                holdD = 1'b1;
    else if (strobes.flowRelease)            holdD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ         <= 1'b0;
      rxTrigFlag    <= 1'b0;
      flowDelayFlag <= 1'b0;
      rtsN          <= 1'b1;
    end else begin
      holdQ         <= holdD;
      rxTrigFlag    <= strobes.trigHit;
      flowDelayFlag <= strobes.flowHit;
      rtsN          <= flowCtlMode ? holdD : !swRts;
    end
  end

  assert_rts_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flowCtlMode && strobes.flowHit) |=> (rtsN && flowDelayFlag));
  assert_rts_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flowCtlMode && holdQ && strobes.flowEnable && !strobes.flowRelease) |=> rtsN);
  assert_sw_rts_R7: assert property (@(posedge clk) disable iff (!rstN)
    !flowCtlMode |=> (rtsN == !$past(swRts)));
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rx_flow_pkg::*;
#(
  parameter int ThrW = THR_W,
  parameter int LvlW = LVL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LvlW-1:0] fifoLevel,
  input  logic            trigWrEn,
  input  logic [ThrW-1:0] trigWrData,
  input  logic            flowWrEn,
  input  logic [ThrW-1:0] flowWrData,
  input  logic            flowCtlMode,
  input  logic            swRts,
  output logic            rxTrigFlag,
  output logic            flowDelayFlag,
  output logic            rtsN
);
  cmpStrobe_t strobes;

  rx_flow_datapath #(.ThrW(ThrW), .LvlW(LvlW), .Hyst(HYST)) dp_i (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .flowWrEn(flowWrEn), .flowWrData(flowWrData),
    .strobes(strobes)
  );

  rx_flow_control ctl_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .flowCtlMode(flowCtlMode), .swRts(swRts),
    .rxTrigFlag(rxTrigFlag), .flowDelayFlag(flowDelayFlag), .rtsN(rtsN)
  );

  assert_flag_split_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flowDelayFlag && !$past(strobes.trigHit)) |-> !rxTrigFlag);
endmodule

// File: tb/rx_flow_ctrl_tb.sv
module rx_flow_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] fifoLevel = '0;
  logic       trigWrEn = 1'b0, flowWrEn = 1'b0;
  logic [5:0] trigWrData = '0, flowWrData = '0;
  logic       flowCtlMode = 1'b0, swRts = 1'b0;
  logic       rxTrigFlag, flowDelayFlag, rtsN;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the programmed state
  int mTrig = 0, mFlow = 0;
  bit mHold = 0;

  logic [2:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  rx_flow_ctrl dut_i (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .flowWrEn(flowWrEn), .flowWrData(flowWrData),
    .flowCtlMode(flowCtlMode), .swRts(swRts),
    .rxTrigFlag(rxTrigFlag), .flowDelayFlag(flowDelayFlag), .rtsN(rtsN)
  );

  task automatic step(input int lvl, input bit fc, input bit sw,
                      input int trigW, input int flowW, input string tag);
    bit tHit, fEn, fHit, fRel, rts;
    @(negedge clk);
    fifoLevel   = 7'(lvl);
    flowCtlMode = fc;
    swRts       = sw;
    trigWrEn    = (trigW >= 0);
    trigWrData  = 6'(trigW < 0 ? 0 : trigW);
    flowWrEn    = (flowW >= 0);
    flowWrData  = 6'(flowW < 0 ? 0 : flowW);
    tHit = (mTrig != 0) && (lvl >= mTrig);
    fEn  = (mFlow >= 4);
    fHit = fEn && (lvl >= mFlow);
    fRel = fEn && !fHit && (lvl <= mFlow - 4);
    if (!fc || !fEn) mHold = 0;
    else if (fHit)   mHold = 1;
    else if (fRel)   mHold = 0;
    rts = fc ? mHold : !sw;
    expQ.push_back({tHit, fHit, rts});
    tagQ.push_back(tag);
    if (trigW >= 0) mTrig = trigW;
    if (flowW >= 0) mFlow = flowW;
  endtask

  // monitor: compares after every edge once a result is expected
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({rxTrigFlag, flowDelayFlag, rtsN} !== e) begin
          fails++;
          $display("FAIL %s: {trig,flow,rtsN} actual %b expected %b", t,
                   {rxTrigFlag, flowDelayFlag, rtsN}, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({rxTrigFlag, flowDelayFlag, rtsN} !== 3'b001) begin
      fails++;
      $display("FAIL R9: actual %b expected 001", {rxTrigFlag, flowDelayFlag, rtsN});
    end
    @(negedge clk); rstN = 1'b1;
    // R7 software RTS
    step(0, 0, 1, -1, -1, "R7 sw assert");
    step(0, 0, 0, -1, -1, "R7 sw release");
    step(0, 0, 1, -1, -1, "R7 sw assert again");
    // R8/R1 trigger threshold
    step(12, 0, 0, 10, -1, "R8 write cycle uses old trig");
    step(9, 0, 0, -1, -1, "R1 below trig");
    step(10, 0, 0, -1, -1, "R1 at trig");
    step(40, 0, 0, -1, -1, "R1 above trig");
    step(5, 0, 0, -1, -1, "R1 falls");
    step(3, 0, 0, -1, -1, "R10 reset level");
    step(33, 0, 0, -1, -1, "R10 jump past trig");
    // R2
    step(30, 0, 0, 0, -1, "R2 write zero");
    step(63, 0, 0, -1, -1, "R2 disabled at 63");
    step(0, 0, 0, -1, -1, "R2 disabled at 0");
    // R4 flow below 4
    step(40, 1, 0, -1, 3, "R4 write 3");
    step(40, 1, 0, -1, -1, "R4 disabled high level");
    step(3, 1, 0, -1, -1, "R4 disabled at level 3");
    // R5/R6 hysteresis
    step(10, 1, 0, -1, 20, "R8 flow write cycle");
    step(19, 1, 0, -1, -1, "R5 just below");
    step(20, 1, 0, -1, -1, "R5 reach, rts drops");
    step(19, 1, 1, -1, -1, "R6 hold at 19");
    step(17, 1, 1, -1, -1, "R6 hold at 17");
    step(16, 1, 0, -1, -1, "R6 release at 16");
    step(18, 1, 0, -1, -1, "R6 stays asserted");
    step(2, 1, 0, -1, -1, "R10 drop low");
    step(45, 1, 0, -1, -1, "R10 jump past flow");
    step(45, 1, 0, -1, -1, "R3 flag stays, trig off");
    step(10, 1, 0, -1, -1, "R6 release far below");
    // both triggers in one cycle
    step(10, 1, 0, 20, -1, "R1 set trig equal");
    step(20, 1, 0, -1, -1, "R5 both fire together");
    step(15, 1, 0, -1, -1, "R6 hold both off");
    // R8 threshold change under a steady level
    step(15, 1, 0, -1, 10, "R8 old flow governs");
    step(15, 1, 0, -1, -1, "R8 new flow governs");
    step(15, 0, 1, -1, -1, "R7 mode off follows sw");
    step(15, 0, 0, -1, -1, "R7 mode off sw low");
    step(0, 0, 0, -1, -1, "R1 idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule